// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block turns a signed binary angle into its cosine and sine using circular-rotation CORDIC. It is fully unrolled. One register stage folds the angle into the right half-plane. After that, a chain of micro-rotation stages follows, each one registered. Every shift amount and every arctangent constant is fixed in the wiring of its own stage, so there is no programmable shifter and no lookup memory. The CORDIC gain is removed once, by preloading the starting vector with the inverse gain.

The block is used as a streaming function unit. It accepts a new angle on any clock where `in_valid` is high. A full pipe delivers one result per clock. Results come out in the order the angles went in, after a fixed latency, with `out_valid` marking each one.

Top module: `cordic_sincos_pipe`

## Requirements
- R1: `angle_in` is a 16-bit two's complement binary angle. A value a stands for a·π/32768 radians, so 0x4000 is +π/2, 0x8000 is −π and 0xC000 is −π/2.
- R2: For angles whose top two bits are 00 or 11, `cos_out` and `sin_out` are signed Q1.14 values (16384 means 1.0). Each lies within 4 LSB of 16384·cos θ and 16384·sin θ.
- R3: Angles whose top two bits are 01 or 10 are folded by π (the MSB is inverted) and both results are negated at the output. The results meet the same 4 LSB bound, including at ±π/2 and −π.
- R4: The gain is compensated. cos²+sin² of every result lies between (16384−24)² and (16384+24)².
- R5: No result overflows. The magnitude of each output is at most 16392.
- R6: `out_valid` rises exactly 17 clocks after the edge that samples `in_valid` high (1 folding stage plus 16 rotation stages). It is high once per accepted angle and never otherwise.
- R7: Angles presented on consecutive clocks produce results on consecutive clocks, in input order, with none lost.
- R8: While reset is asserted, and after it is released until the first accepted angle has emerged, `out_valid` is low.
- R9: An angle of zero gives `cos_out` within 4 of 16384 and `sin_out` within 4 of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Angle strobe |
| angle_in | input | 16 | Signed binary angle, full scale ±π |
| out_valid | output | 1 | Result strobe, 17 cycles after the matching input |
| cos_out | output | 16 | Cosine, signed Q1.14 |
| sin_out | output | 16 | Sine, signed Q1.14 |

## Verification
A wrong rotation direction, shift or arctangent constant in any stage bends the rotated vector away from its true angle. The sweep over every angle shows this at the output as an error of many LSBs, 17 cycles after the affected input. A lost or misrouted fold flag shows up as a sign error confined to the second and third quadrants. A broken preload shows up as a wrong magnitude on every result. A fault in the strobe pipe shows up as a result one cycle early or late, or as a gap in a back-to-back stream.

// File: rtl/cordic_sincos_pkg.sv
package cordic_sincos_pkg;

  // inverse of the accumulated circular CORDIC gain
  localparam real GAIN_INV = 0.6072529350;

  // arctangent of 2^-i, expressed where pi equals 2^19
  function automatic longint atan_c19(input int i);
    longint c;
    case (i)
      0:  c = 131072;
      1:  c = 77376;
      2:  c = 40884;
      3:  c = 20753;
      4:  c = 10417;
      5:  c = 5213;
      6:  c = 2607;
      7:  c = 1304;
      8:  c = 652;
      9:  c = 326;
      10: c = 163;
      11: c = 81;
      12: c = 41;
      13: c = 20;
      14: c = 10;
      15: c = 5;
      default: c = (i > 40) ? 64'sd0 : (longint'(166886) >>> i);
    endcase
    return c;
  endfunction

  // same constant rescaled so that pi equals 2^(zw-1)
  function automatic longint atan_fix(input int i, input int zw);
    longint c;
    c = atan_c19(i);
    if (zw >= 20) return c <<< (zw - 20);
    else          return c >>> (20 - zw);
  endfunction

endpackage

// File: rtl/cordic_rst_sync.sv
module cordic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cordic_fold.sv
module cordic_fold #(
  parameter int ANG_W = 16,
  parameter int ZW    = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [ANG_W-1:0]     angle_in,
  output logic                 v_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 neg_o
);
  localparam int PAD = ZW - ANG_W;

  logic                 flip;
  logic [ANG_W-1:0]     folded;
  logic signed [ZW-1:0] z_n;
  logic                 v_q;
  logic signed [ZW-1:0] z_q;
  logic                 neg_q;

  // second or third quadrant when the two top bits differ
  always_comb begin
    flip   = angle_in[ANG_W-1] ^ angle_in[ANG_W-2];
    folded = angle_in;
    folded[ANG_W-1] = angle_in[ANG_W-1] ^ flip;
    z_n    = {folded, {PAD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      z_q   <= '0;
      neg_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        z_q   <= z_n;
        neg_q <= flip;
      end
    end
  end

  assign v_o   = v_q;
  assign z_o   = z_q;
  assign neg_o = neg_q;
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int XW  = 20,
  parameter int ZW  = 20,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic                 neg_i,
  output logic                 v_o,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 neg_o
);
  // tied-off rotation angle for this stage
  localparam logic signed [ZW-1:0] ATAN_K = ZW'(cordic_sincos_pkg::atan_fix(IDX, ZW));

  logic signed [XW-1:0] x_sh;
  logic signed [XW-1:0] y_sh;
  logic signed [XW-1:0] x_n;
  logic signed [XW-1:0] y_n;
  logic signed [ZW-1:0] z_n;
  logic                 v_q;
  logic signed [XW-1:0] x_q;
  logic signed [XW-1:0] y_q;
  logic signed [ZW-1:0] z_q;
  logic                 neg_q;

  always_comb begin
    x_sh = x_i >>> IDX;
    y_sh = y_i >>> IDX;
    if (!z_i[ZW-1]) begin
      x_n = x_i - y_sh;
      y_n = y_i + x_sh;
      z_n = z_i - ATAN_K;
    end else begin
      x_n = x_i + y_sh;
      y_n = y_i - x_sh;
      z_n = z_i + ATAN_K;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      neg_q <= 1'b0;
    end else begin
      v_q <= v_i;
      if (v_i) begin
        x_q   <= x_n;
        y_q   <= y_n;
        z_q   <= z_n;
        neg_q <= neg_i;
      end
    end
  end

  assign v_o   = v_q;
  assign x_o   = x_q;
  assign y_o   = y_q;
  assign z_o   = z_q;
  assign neg_o = neg_q;
endmodule

// File: rtl/cordic_post.sv
module cordic_post #(
  parameter int XW    = 20,
  parameter int OUT_W = 16,
  parameter int GUARD = 3
) (
  input  logic                    neg_i,
  input  logic signed [XW-1:0]    x_i,
  input  logic signed [XW-1:0]    y_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  localparam logic signed [XW-1:0] HALF = XW'(1) <<< (GUARD - 1);
  localparam logic signed [XW-1:0] MAXV = XW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [XW-1:0] MINV = -MAXV;

  function automatic logic signed [OUT_W-1:0] shape(
    input logic signed [XW-1:0] v,
    input logic                 neg
  );
    logic signed [XW-1:0] r;
    logic signed [XW-1:0] s;
    r = (v + HALF) >>> GUARD;
    if (r > MAXV)      s = MAXV;
    else if (r < MINV) s = MINV;
    else               s = r;
    if (neg) s = -s;
    return s[OUT_W-1:0];
  endfunction

  always_comb begin
    cos_o = shape(x_i, neg_i);
    sin_o = shape(y_i, neg_i);
  end
endmodule

// File: rtl/cordic_sincos_pipe.sv
module cordic_sincos_pipe #(
  parameter int ANG_W  = 16,
  parameter int OUT_W  = 16,
  parameter int STAGES = 16,
  parameter int GUARD  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [ANG_W-1:0]        angle_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] sin_out
);
  localparam int XW  = OUT_W + GUARD + 1;
  localparam int ZW  = ANG_W + 4;
  localparam int LAT = STAGES + 1;
  localparam logic signed [XW-1:0] X_INIT =
    XW'($rtoi(cordic_sincos_pkg::GAIN_INV * (2.0 ** (OUT_W - 2 + GUARD)) + 0.5));

  logic rst_sync_n;

  logic                 sv [0:STAGES];
  logic signed [XW-1:0] sx [0:STAGES];
  logic signed [XW-1:0] sy [0:STAGES];
  logic signed [ZW-1:0] sz [0:STAGES];
  logic                 sn [0:STAGES];

  cordic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cordic_fold #(.ANG_W(ANG_W), .ZW(ZW)) u_fold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .angle_in (angle_in),
    .v_o      (sv[0]),
    .z_o      (sz[0]),
    .neg_o    (sn[0])
  );

  // gain compensation: the starting vector is preloaded
  assign sx[0] = X_INIT;
  assign sy[0] = '0;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cordic_stage #(.XW(XW), .ZW(ZW), .IDX(i)) u_stage (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .v_i   (sv[i]),
      .x_i   (sx[i]),
      .y_i   (sy[i]),
      .z_i   (sz[i]),
      .neg_i (sn[i]),
      .v_o   (sv[i+1]),
      .x_o   (sx[i+1]),
      .y_o   (sy[i+1]),
      .z_o   (sz[i+1]),
      .neg_o (sn[i+1])
    );
  end

  cordic_post #(.XW(XW), .OUT_W(OUT_W), .GUARD(GUARD)) u_post (
    .neg_i (sn[STAGES]),
    .x_i   (sx[STAGES]),
    .y_i   (sy[STAGES]),
    .cos_o (cos_out),
    .sin_o (sin_out)
  );

  assign out_valid = sv[STAGES];
endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int ANG_W = 16,
  parameter int OUT_W = 16,
  parameter int LAT   = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [ANG_W-1:0]        angle_in,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] cos_out,
  input logic signed [OUT_W-1:0] sin_out
);
  localparam longint ONE = longint'(1) << (OUT_W - 2);
  localparam longint TOL = 4;
  localparam longint LO2 = (ONE - 24) * (ONE - 24);
  localparam longint HI2 = (ONE + 24) * (ONE + 24);

  // per entry: {valid, top two angle bits, angle is zero}
  logic [LAT-1:0][3:0] hist_q;
  logic [3:0]          head;
  logic                old_v;
  logic [1:0]          old_q;
  logic                old_zero;
  longint              c_l;
  longint              s_l;
  longint              mag2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[LAT-2:0], in_valid, angle_in[ANG_W-1:ANG_W-2], (angle_in == '0)};
  end

  always_comb begin
    head     = hist_q[LAT-1];
    old_v    = head[3];
    old_q    = head[2:1];
    old_zero = head[0];
    c_l      = longint'(cos_out);
    s_l      = longint'(sin_out);
    mag2     = c_l * c_l + s_l * s_l;
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == old_v);

  a_r8_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

  a_r4_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mag2 >= LO2 && mag2 <= HI2));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (c_l <= ONE + 8 && c_l >= -(ONE + 8) && s_l <= ONE + 8 && s_l >= -(ONE + 8)));

  a_r3_cos_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((old_q[1] ^ old_q[0]) ? (c_l <= TOL) : (c_l >= -TOL)));

  a_r3_sin_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (old_q[1] ? (s_l <= TOL) : (s_l >= -TOL)));

  a_r9_zero_angle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && old_zero) |-> (c_l >= ONE - TOL && c_l <= ONE + TOL && s_l >= -TOL && s_l <= TOL));
endmodule

bind cordic_sincos_pipe cordic_sincos_chk #(
  .ANG_W (ANG_W),
  .OUT_W (OUT_W),
  .LAT   (LAT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .angle_in  (angle_in),
  .out_valid (out_valid),
  .cos_out   (cos_out),
  .sin_out   (sin_out)
);

// File: tb/cordic_sincos_pipe_tb_top.sv
module cordic_sincos_pipe_tb_top;
  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [15:0]        angle_in;
  logic               out_valid;
  logic signed [15:0] cos_out;
  logic signed [15:0] sin_out;

  int total;
  int bad;
  int qa [0:255];
  int wr_cnt;
  int rd_cnt;
  bit done;

  cordic_sincos_pipe dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .angle_in  (angle_in),
    .out_valid (out_valid),
    .cos_out   (cos_out),
    .sin_out   (sin_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic put(input logic v, input logic [15:0] a);
    @(negedge clk);
    in_valid = v;
    angle_in = a;
    if (v) begin
      qa[wr_cnt & 255] = int'(a);
      wr_cnt++;
    end
  endtask

  // output monitor: compare every result with the real-valued function
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (rd_cnt >= wr_cnt) begin
        bad++;
        $display("FAIL R6 result without input: actual out_valid=1 expected 0");
      end else begin
        int     a;
        int     sa;
        real    th;
        real    ec;
        real    es;
        real    dc;
        real    ds;
        int     ci;
        int     si;
        longint m2;
        string  tag;
        a  = qa[rd_cnt & 255];
        rd_cnt++;
        sa = (a >= 32768) ? a - 65536 : a;
        th = $itor(sa) * 3.14159265358979 / 32768.0;
        ec = $cos(th) * 16384.0;
        es = $sin(th) * 16384.0;
        ci = cos_out;
        si = sin_out;
        dc = $itor(ci) - ec;
        ds = $itor(si) - es;
        if (dc < 0.0) dc = -dc;
        if (ds < 0.0) ds = -ds;
        if (a == 0) tag = "R9";
        else if (((a >> 15) & 1) != ((a >> 14) & 1)) tag = "R3";
        else tag = "R2";
        // R1 R2 R3 R9: value within 4 LSB
        if (dc > 4.0 || ds > 4.0) begin
          bad++;
          $display("FAIL %s R1 angle=%h actual cos=%0d sin=%0d expected cos=%f sin=%f",
                   tag, a[15:0], ci, si, ec, es);
        end
        total++;
        m2 = longint'(ci) * ci + longint'(si) * si;
        if (m2 < longint'(16360) * 16360 || m2 > longint'(16408) * 16408) begin
          bad++;
          $display("FAIL R4 angle=%h actual mag2=%0d expected about %0d", a[15:0], m2, 16384 * 16384);
        end
        total++;
        if (ci > 16392 || ci < -16392 || si > 16392 || si < -16392) begin
          bad++;
          $display("FAIL R5 angle=%h actual cos=%0d sin=%0d expected magnitude <= 16392", a[15:0], ci, si);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    logic [15:0] edges [0:11];
    total = 0; bad = 0; wr_cnt = 0; rd_cnt = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; angle_in = '0;
    repeat (3) @(negedge clk);
    // R8: no result while reset is held
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 during reset actual out_valid=%b expected 0", out_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 after release actual out_valid=%b expected 0", out_valid);
    end

    // R6: single angle, count cycles to the result
    put(1'b1, 16'h2000);
    seen = 0;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (out_valid && seen == 0) seen = k;
    end
    total++;
    if (seen != 17) begin
      bad++;
      $display("FAIL R6 latency actual=%0d expected=17", seen);
    end

    // R7 R1 R2 R3: every angle, back to back
    for (int a = 0; a < 65536; a++) put(1'b1, 16'(a));
    put(1'b0, 16'h0000);
    repeat (30) @(negedge clk);
    total++;
    if (rd_cnt != wr_cnt) begin
      bad++;
      $display("FAIL R7 results delivered actual=%0d expected=%0d", rd_cnt, wr_cnt);
    end

    // R3 R6: quadrant boundaries with gaps in the strobe
    edges[0] = 16'h0000; edges[1] = 16'h3FFF; edges[2] = 16'h4000; edges[3] = 16'h4001;
    edges[4] = 16'h7FFF; edges[5] = 16'h8000; edges[6] = 16'h8001; edges[7] = 16'hBFFF;
    edges[8] = 16'hC000; edges[9] = 16'hC001; edges[10] = 16'hFFFF; edges[11] = 16'h0001;
    for (int e = 0; e < 12; e++) begin
      put(1'b1, edges[e]);
      if (e % 3 == 1) put(1'b0, 16'h5555);
    end
    put(1'b0, 16'h0000);
    repeat (30) @(negedge clk);
    total++;
    if (rd_cnt != wr_cnt) begin
      bad++;
      $display("FAIL R6 gapped results actual=%0d expected=%0d", rd_cnt, wr_cnt);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule